// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Pair

This block joins two eight-line interrupt units into one sixteen-line system. Lines 0 to 7 belong to the primary unit. Lines 8 to 15 belong to the secondary unit, and the secondary's combined request output feeds primary slot 2. Each request input is edge-detected against a copy registered every clock. A rising edge latches a pending request, and a falling edge withdraws it.

Each unit holds a per-line trigger-mode register. A line marked level keeps its request through an acknowledge. A line marked edge loses its request when it is acknowledged. Some bits of the trigger-mode register are fixed. The cascade slot of the primary unit is always level and never shows on readback. A few lines can never be switched to level.

A single acknowledge strobe resolves the primary first. If the cascade slot wins, the secondary is acknowledged in the same cycle. The block then returns a vector made of the responding unit's base and the winning line. A small register port sets the bases and the trigger modes.

Top module: `cascadedIrqPair`

## Requirements
- R1: After reset `cpuInt` and `vecValid` are low. The trigger-mode register of each unit reads 0x00, and each base reads 0x00.
- R2: A rising edge on request input N, sampled at a clock edge, makes `cpuInt` high after that edge. A falling edge withdraws the pending request after the edge at which it is sampled.
- R3: Request input 2 is ignored. No level or edge on it raises `cpuInt` or produces a vector.
- R4: Within a unit, the lowest numbered pending line wins. The secondary competes as primary slot 2. Lines 0 and 1 therefore beat lines 8 to 15, and lines 8 to 15 beat lines 3 to 7.
- R5: An acknowledge strobe held for one cycle while `cpuInt` is high yields a vector after that clock edge. `vecValid` is high for that one cycle. The vector is the responding unit's base with bits 2:0 replaced by the winning line number within that unit, so a secondary winner returns secondary base plus (N-8).
- R6: An acknowledge strobe while `cpuInt` is low leaves `vecValid` low.
- R7: An acknowledge clears the winner's request if its trigger-mode bit is 0 (edge). If the bit is 1 (level), the request stays pending while its input stays high.
- R8: Register address 0 is the primary trigger mode, one bit per line. A write stores the data ANDed with 0xF8 and then forces bit 2 to 1. A read returns the stored value ANDed with 0xF8. Lines 0 and 1 therefore always act as edge.
- R9: Register address 1 is the secondary trigger mode. A write stores the data ANDed with 0xDE, and a read returns the stored value. Lines 8 and 13 therefore always act as edge.
- R10: The secondary's request output drives primary slot 2 with no extra delay. When the last secondary request clears and no primary line is pending, `cpuInt` falls.
- R11: Register addresses 2 and 3 are the primary and secondary bases. A write keeps bits 7:3 of the data, and a read returns them with bits 2:0 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 16 | Request inputs; bit N is global line N |
| ackStrobe | input | 1 | One-cycle acknowledge request |
| regWe | input | 1 | Register write enable |
| regAddr | input | 2 | Register select (0/1 trigger mode, 2/3 base) |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for `regAddr`, combinational |
| cpuInt | output | 1 | Interrupt line toward the processor |
| vecOut | output | 8 | Acknowledged vector |
| vecValid | output | 1 | `vecOut` holds a fresh vector this cycle |

## Verification
The bench builds the block with its defaults: eight lines per unit, an 8-bit vector, cascade slot 2, and the fixed-bit masks 0xF8 and 0xDE. With these values the bench can reach the cascade hand-off, the ignored input 2, and both hard-wired edge lines of each unit, and it can check the exact vector numbers against the bases it programs. A wider unit or a different slot would move the hidden bits and the vector split. Those cases are not covered here.

// File: rtl/irqPairPkg.sv
package irqPairPkg;
  typedef struct packed {
    logic [1:0] lvlWr;    // trigger-mode write, [0] primary, [1] secondary
    logic [1:0] baseWr;   // base write
    logic [1:0] ackTake;  // acknowledge applied to unit
  } ctrlStrobes_t;
endpackage

// File: rtl/irqUnit.sv
module irqUnit #(
  parameter int LINES = 8,
  parameter int VECW = 8,
  parameter bit IS_PRIMARY = 1'b0,
  parameter int CASC_LINE = 2,
  parameter logic [LINES-1:0] LVL_MASK = '1,
  parameter logic [LINES-1:0] LVL_FORCE = '0,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  rise,
  input  logic [LINES-1:0]  fall,
  input  logic              cascadeIn,
  input  logic              lvlWr,
  input  logic              baseWr,
  input  logic [VECW-1:0]   wrData,
  input  logic              ackTake,
  output logic              anyReq,
  output logic [IDXW-1:0]   winIdx,
  output logic [VECW-1:0]   vec,
  output logic [LINES-1:0]  lvlRd,
  output logic [VECW-1:0]   baseRd
);
  localparam logic [VECW-1:0] BASE_KEEP = ~VECW'((1 << IDXW) - 1);

  logic [LINES-1:0] reqQ, lvlQ, pend, ackClr;
  logic [VECW-1:0]  baseQ;

  generate
    if (IS_PRIMARY) begin : g_casc
      always_comb begin
        pend = reqQ;
        pend[CASC_LINE] = reqQ[CASC_LINE] | cascadeIn;
      end
    end else begin : g_plain
      logic unusedCasc;
      assign unusedCasc = cascadeIn;
      assign pend = reqQ;
    end
  endgenerate

  always_comb begin
    winIdx = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (pend[i]) winIdx = IDXW'(i);
  end

  assign anyReq = |pend;
  assign ackClr = ackTake ? ((LINES'(1) << winIdx) & ~lvlQ) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ  <= '0;
      lvlQ  <= LVL_FORCE;
      baseQ <= '0;
    end else begin
      reqQ <= ((reqQ | rise) & ~fall) & ~ackClr;
      if (lvlWr)  lvlQ  <= (wrData[LINES-1:0] & LVL_MASK) | LVL_FORCE;
      if (baseWr) baseQ <= wrData & BASE_KEEP;
    end
  end

  assign vec    = baseQ | VECW'(winIdx);
  assign lvlRd  = lvlQ & LVL_MASK;
  assign baseRd = baseQ;
endmodule

// File: rtl/pairCtrl.sv
module pairCtrl
  import irqPairPkg::*;
#(
  parameter int LINES = 8,
  parameter int VECW = 8,
  parameter int CASC_LINE = 2,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ackStrobe,
  input  logic            regWe,
  input  logic [1:0]      regAddr,
  input  logic            primReq,
  input  logic [IDXW-1:0] primWin,
  input  logic [VECW-1:0] primVec,
  input  logic [VECW-1:0] secVec,
  output ctrlStrobes_t    strb,
  output logic [VECW-1:0] vecOut,
  output logic            vecValid
);
  logic take, viaSec;

  assign take   = ackStrobe && primReq;
  assign viaSec = take && (primWin == IDXW'(CASC_LINE));

  always_comb begin
    strb = '0;
    strb.lvlWr[0]   = regWe && (regAddr == 2'd0);
    strb.lvlWr[1]   = regWe && (regAddr == 2'd1);
    strb.baseWr[0]  = regWe && (regAddr == 2'd2);
    strb.baseWr[1]  = regWe && (regAddr == 2'd3);
    strb.ackTake[0] = take;
    strb.ackTake[1] = viaSec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      vecValid <= take;
      if (take) vecOut <= viaSec ? secVec : primVec;
    end
  end
endmodule

// File: rtl/cascadedIrqPair.sv
module cascadedIrqPair
  import irqPairPkg::*;
#(
  parameter int LINES = 8,
  parameter int VECW = 8,
  parameter int CASC_LINE = 2,
  parameter logic [LINES-1:0] PRIM_LVL_MASK = 8'hF8,
  parameter logic [LINES-1:0] SEC_LVL_MASK = 8'hDE,
  localparam int TOTAL = 2 * LINES,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TOTAL-1:0] irqIn,
  input  logic             ackStrobe,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [VECW-1:0]  regWdata,
  output logic [VECW-1:0]  regRdata,
  output logic             cpuInt,
  output logic [VECW-1:0]  vecOut,
  output logic             vecValid
);
  localparam logic [TOTAL-1:0] SEEN_MASK = ~(TOTAL'(1) << CASC_LINE);
  localparam logic [LINES-1:0] PRIM_FORCE = LINES'(1) << CASC_LINE;

  ctrlStrobes_t     strb;
  logic [TOTAL-1:0] irqSeen, irqPrev, rise, fall;
  logic             primReq, secReq;
  logic [IDXW-1:0]  primWin, secWin;
  logic [VECW-1:0]  primVec, secVec, primBase, secBase;
  logic [LINES-1:0] primLvl, secLvl;

  assign irqSeen = irqIn & SEEN_MASK;
  assign rise = irqSeen & ~irqPrev;
  assign fall = ~irqSeen & irqPrev;

  always_ff @(posedge clk) begin
    if (!rstN) irqPrev <= '0;
    else       irqPrev <= irqSeen;
  end

  irqUnit #(.LINES(LINES), .VECW(VECW), .IS_PRIMARY(1'b1), .CASC_LINE(CASC_LINE),
            .LVL_MASK(PRIM_LVL_MASK), .LVL_FORCE(PRIM_FORCE)) uPrim (
    .clk(clk), .rstN(rstN), .rise(rise[LINES-1:0]), .fall(fall[LINES-1:0]),
    .cascadeIn(secReq), .lvlWr(strb.lvlWr[0]), .baseWr(strb.baseWr[0]),
    .wrData(regWdata), .ackTake(strb.ackTake[0]), .anyReq(primReq),
    .winIdx(primWin), .vec(primVec), .lvlRd(primLvl), .baseRd(primBase));

  irqUnit #(.LINES(LINES), .VECW(VECW), .IS_PRIMARY(1'b0), .CASC_LINE(CASC_LINE),
            .LVL_MASK(SEC_LVL_MASK), .LVL_FORCE('0)) uSec (
    .clk(clk), .rstN(rstN), .rise(rise[TOTAL-1:LINES]), .fall(fall[TOTAL-1:LINES]),
    .cascadeIn(1'b0), .lvlWr(strb.lvlWr[1]), .baseWr(strb.baseWr[1]),
    .wrData(regWdata), .ackTake(strb.ackTake[1]), .anyReq(secReq),
    .winIdx(secWin), .vec(secVec), .lvlRd(secLvl), .baseRd(secBase));

  pairCtrl #(.LINES(LINES), .VECW(VECW), .CASC_LINE(CASC_LINE)) uCtrl (
    .clk(clk), .rstN(rstN), .ackStrobe(ackStrobe), .regWe(regWe), .regAddr(regAddr),
    .primReq(primReq), .primWin(primWin), .primVec(primVec), .secVec(secVec),
    .strb(strb), .vecOut(vecOut), .vecValid(vecValid));

  logic [IDXW-1:0] unusedWin;
  assign unusedWin = secWin;

  always_comb begin
    case (regAddr)
      2'd0:    regRdata = VECW'(primLvl);
      2'd1:    regRdata = VECW'(secLvl);
      2'd2:    regRdata = primBase;
      default: regRdata = secBase;
    endcase
  end

  assign cpuInt = primReq;
endmodule

// File: rtl/pairChecker.sv
module pairChecker (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] irqIn,
  input logic        ackStrobe,
  input logic [1:0]  regAddr,
  input logic [7:0]  regRdata,
  input logic        cpuInt,
  input logic        vecValid
);
  AST_QUIET_INPUTS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(irqIn) == 16'h0) |-> !cpuInt);                                   // R2
  AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> ($past(ackStrobe) && $past(cpuInt)));                      // R5
  AST_IDLE_ACK_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !cpuInt) |=> !vecValid);                                  // R6
  AST_PRIM_LVL_HIDDEN: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd0) |-> (regRdata[2:0] == 3'b000));                       // R8
  AST_SEC_LVL_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd1) |-> ((regRdata & 8'h21) == 8'h00));                   // R9
  AST_BASE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regAddr[1] |-> (regRdata[2:0] == 3'b000));                              // R11
endmodule

bind cascadedIrqPair pairChecker uChk (
  .clk(clk), .rstN(rstN), .irqIn(irqIn), .ackStrobe(ackStrobe),
  .regAddr(regAddr), .regRdata(regRdata), .cpuInt(cpuInt), .vecValid(vecValid));

// File: tb/tb_cascadedIrqPair.sv
module tb_cascadedIrqPair;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqIn = '0;
  logic        ackStrobe = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [7:0]  regWdata = '0;
  logic [7:0]  regRdata, vecOut;
  logic        cpuInt, vecValid;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cascadedIrqPair dut (.clk(clk), .rstN(rstN), .irqIn(irqIn), .ackStrobe(ackStrobe),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .cpuInt(cpuInt), .vecOut(vecOut), .vecValid(vecValid));

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(string req, logic [1:0] a, logic [7:0] exp);
    regAddr = a;
    #1;
    chk(req, "readback", regRdata, exp);
  endtask

  task automatic setLine(int n, logic v);
    irqIn[n] = v;
    @(negedge clk);
  endtask

  task automatic doAck(string req, logic expValid, logic [7:0] expVec);
    ackStrobe = 1'b1;
    @(negedge clk);
    ackStrobe = 1'b0;
    chk(req, "vecValid", 8'(vecValid), 8'(expValid));
    if (expValid) chk(req, "vecOut", vecOut, expVec);
  endtask

  task automatic tReset;
    chk("R1", "cpuInt", 8'(cpuInt), 8'h0);
    chk("R1", "vecValid", 8'(vecValid), 8'h0);
    rdReg("R1", 2'd0, 8'h00); rdReg("R1", 2'd1, 8'h00);
    rdReg("R1", 2'd2, 8'h00); rdReg("R1", 2'd3, 8'h00);
  endtask

  task automatic tBases;
    wrReg(2'd2, 8'h47); rdReg("R11", 2'd2, 8'h40);
    wrReg(2'd3, 8'h70); rdReg("R11", 2'd3, 8'h70);
  endtask

  task automatic tEdge;
    setLine(5, 1'b1);
    chk("R2", "cpuInt rise", 8'(cpuInt), 8'h1);
    doAck("R5", 1'b1, 8'h45);
    chk("R7", "edge cleared", 8'(cpuInt), 8'h0);
    setLine(5, 1'b0);
    setLine(6, 1'b1);
    chk("R2", "cpuInt line6", 8'(cpuInt), 8'h1);
    setLine(6, 1'b0);
    chk("R2", "fall withdraws", 8'(cpuInt), 8'h0);
  endtask

  task automatic tIgnored;
    setLine(2, 1'b1);
    chk("R3", "line2 ignored", 8'(cpuInt), 8'h0);
    doAck("R6", 1'b0, 8'h00);
    setLine(2, 1'b0);
    chk("R3", "line2 fall", 8'(cpuInt), 8'h0);
  endtask

  task automatic tSecondary;
    setLine(12, 1'b1);
    chk("R10", "cascade raises", 8'(cpuInt), 8'h1);
    doAck("R5", 1'b1, 8'h74);
    chk("R10", "cascade drops", 8'(cpuInt), 8'h0);
    setLine(12, 1'b0);
  endtask

  task automatic tPriority;
    irqIn[1] = 1'b1; irqIn[3] = 1'b1; irqIn[9] = 1'b1;
    @(negedge clk);
    doAck("R4", 1'b1, 8'h41);
    doAck("R4", 1'b1, 8'h71);
    doAck("R4", 1'b1, 8'h43);
    chk("R4", "all served", 8'(cpuInt), 8'h0);
    irqIn = '0;
    @(negedge clk);
  endtask

  task automatic tPrimLevel;
    wrReg(2'd0, 8'hFF); rdReg("R8", 2'd0, 8'hF8);
    setLine(3, 1'b1);
    doAck("R7", 1'b1, 8'h43);
    chk("R7", "level stays", 8'(cpuInt), 8'h1);
    setLine(3, 1'b0);
    chk("R7", "level fall", 8'(cpuInt), 8'h0);
    setLine(0, 1'b1);
    doAck("R8", 1'b1, 8'h40);
    chk("R8", "line0 forced edge", 8'(cpuInt), 8'h0);
    setLine(0, 1'b0);
  endtask

  task automatic tSecLevel;
    wrReg(2'd1, 8'hFF); rdReg("R9", 2'd1, 8'hDE);
    setLine(8, 1'b1);
    doAck("R9", 1'b1, 8'h70);
    chk("R9", "line8 forced edge", 8'(cpuInt), 8'h0);
    setLine(9, 1'b1);
    doAck("R9", 1'b1, 8'h71);
    chk("R9", "line9 level", 8'(cpuInt), 8'h1);
    setLine(9, 1'b0);
    chk("R10", "secondary empty", 8'(cpuInt), 8'h0);
    setLine(8, 1'b0);
  endtask

  task automatic finishRun;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBases();
    tEdge();
    tIgnored();
    tSecondary();
    tPriority();
    tPrimLevel();
    tSecLevel();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end
endmodule